// File: doc/BRIEF.md
# Double-Buffered Pseudo-Random Word Streamer

This block produces a stream of uniformly distributed 32-bit unsigned integers with the MT19937 recurrence, whose period is 2^19937 - 1. It writes them into host memory over a burst write request port. Host memory holds two buffers, and the block fills them in turn, starting with buffer A. Each buffer has an ownership flag. The block writes a buffer only while the host has marked it empty. When a buffer is complete, the block marks it full and moves to the other buffer. The host drains one buffer while the generator refills the other.

A start pulse captures the seed, the buffer size and the two buffer base addresses. The block then expands the seed into its 624-word state, which takes 624 cycles, and begins streaming. Each write goes out as a 64-byte burst of sixteen 32-bit beats with a valid/ready handshake per beat. Back-pressure from the memory path stalls generation, and no value is lost or repeated.

Top module: `mtg_pingpong_gen`

## Requirements
- R1: After a start pulse is accepted, `wr_valid_o` stays low for at least 624 cycles while the seed is expanded. The first beat is offered no later than 640 cycles after start.
- R2: The data of the accepted beats, in order, equals the MT19937 tempered output sequence for the captured seed. For seed 5489 the first word is 3499211612.
- R3: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o` stays high and data, address and last hold their values. No value is dropped or repeated.
- R4: Every burst has exactly 16 beats. `wr_len_o` reads 16. `wr_last_o` is high on the 16th beat only. `wr_addr_o` carries the byte address of the burst's first word and holds it through all beats.
- R5: Buffers are filled alternately, starting with A. A word at offset k of a buffer goes to byte address base + 4*k. The buffer size in words is `buf_words_i` captured at start, with its low 4 bits forced to zero.
- R6: `buf_full_o[0]` is the flag of buffer A and `buf_full_o[1]` is the flag of buffer B, where 1 means full. A flag rises in the cycle after the last beat of that buffer is accepted, and never at any other time.
- R7: No beat is offered while the flag of the buffer being written is full. Writing resumes after the host clears that flag.
- R8: A one-cycle pulse on `host_empty_i[b]` clears flag b from the next cycle. A pulse on a flag that is already empty has no effect.
- R9: Once the block has started, further start pulses and changes to the seed, size or base inputs are ignored.
- R10: During and right after reset, `wr_valid_o` is low and both flags are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the configuration and begins seeding |
| seed_i | input | 32 | Generator seed |
| buf_words_i | input | SW | Buffer size in words (multiple of 16) |
| base_a_i | input | AW | Byte base address of buffer A |
| base_b_i | input | AW | Byte base address of buffer B |
| host_empty_i | input | 2 | Host pulse that marks a buffer empty |
| buf_full_o | output | 2 | Buffer ownership flags, 1 = full |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | AW | Byte address of the current burst |
| wr_len_o | output | LW | Burst length in beats |
| wr_data_o | output | 32 | Beat data |
| wr_last_o | output | 1 | Final beat of the burst |

## Verification
The hardest situation to reach is a stall on ownership: both buffers are full while a fresh word is already waiting inside the generator. The bench gets there by holding back the empty pulse for one completed buffer for 200 cycles, while the host drains the other buffer quickly. It also applies a long stretch of low ready in the middle of a burst, together with random ready throttling, and compares every accepted beat against a bulk-twist reference model over 1000 words.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    localparam int unsigned STATE_WORDS = 624;
    localparam int unsigned SHIFT_DIST  = 397;
    localparam logic [31:0] TWIST_XOR   = 32'h9908_B0DF;
    localparam logic [31:0] HI_MASK     = 32'h8000_0000;
    localparam logic [31:0] LO_MASK     = 32'h7FFF_FFFF;
    localparam logic [31:0] INIT_MUL    = 32'd1812433253;

    typedef enum logic [1:0] {
        CORE_IDLE = 2'd0,
        CORE_SEED = 2'd1,
        CORE_RUN  = 2'd2
    } core_st_e;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_WAIT  = 2'd1,
        WR_BURST = 2'd2
    } wr_st_e;

    function automatic logic [31:0] temper(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x >> 11);
        y = y ^ ((y << 7) & 32'h9D2C_5680);
        y = y ^ ((y << 15) & 32'hEFC6_0000);
        y = y ^ (y >> 18);
        return y;
    endfunction

    function automatic logic [31:0] twist(input logic [31:0] cur,
                                          input logic [31:0] nxt,
                                          input logic [31:0] far);
        logic [31:0] y;
        y = (cur & HI_MASK) | (nxt & LO_MASK);
        return far ^ (y >> 1) ^ (y[0] ? TWIST_XOR : 32'h0);
    endfunction

    function automatic logic [31:0] seed_step(input logic [31:0] prev,
                                              input logic [31:0] pos);
        return INIT_MUL * (prev ^ (prev >> 30)) + pos;
    endfunction

endpackage

// File: rtl/mtg_core.sv
module mtg_core
    import mtg_pkg::*;
#(
    parameter int N = STATE_WORDS,
    parameter int M = SHIFT_DIST
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] seed_i,
    input  logic        take_i,
    output logic        word_vld_o,
    output logic [31:0] word_o
);

    localparam int IW = $clog2(N);

    typedef struct packed {
        core_st_e        st;
        logic [IW-1:0]   idx;
        logic [31:0]     prev;
        logic [31:0]     word;
        logic            vld;
    } core_t;

    core_t r_q, r_d;

    logic [31:0]   mt_q [N];
    logic          we;
    logic [IW-1:0] waddr;
    logic [31:0]   wdata;
    logic [IW-1:0] idx_nx, idx_far;
    logic [31:0]   fresh;

    always_comb begin
        idx_nx  = (r_q.idx == IW'(N - 1)) ? '0 : r_q.idx + 1'b1;
        idx_far = (r_q.idx >= IW'(N - M)) ? r_q.idx - IW'(N - M)
                                          : r_q.idx + IW'(M);
        fresh   = twist(mt_q[r_q.idx], mt_q[idx_nx], mt_q[idx_far]);
    end

    always_comb begin
        r_d   = r_q;
        we    = 1'b0;
        waddr = r_q.idx;
        wdata = '0;
        unique case (r_q.st)
            CORE_IDLE: begin
                if (load_i) begin
                    r_d.st   = CORE_SEED;
                    r_d.idx  = '0;
                    r_d.prev = seed_i;
                    r_d.vld  = 1'b0;
                end
            end
            CORE_SEED: begin
                we       = 1'b1;
                wdata    = (r_q.idx == '0) ? r_q.prev
                                           : seed_step(r_q.prev, 32'(r_q.idx));
                r_d.prev = wdata;
                if (r_q.idx == IW'(N - 1)) begin
                    r_d.st  = CORE_RUN;
                    r_d.idx = '0;
                end else begin
                    r_d.idx = idx_nx;
                end
            end
            CORE_RUN: begin
                if (!r_q.vld || take_i) begin
                    we       = 1'b1;
                    wdata    = fresh;
                    r_d.word = temper(fresh);
                    r_d.vld  = 1'b1;
                    r_d.idx  = idx_nx;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (we) mt_q[waddr] <= wdata;
    end

    assign word_vld_o = r_q.vld;
    assign word_o     = r_q.word;

endmodule

// File: rtl/mtg_writer.sv
module mtg_writer
    import mtg_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SW    = 16,
    parameter int BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] buf_words_i,
    input  logic [AW-1:0] base_a_i,
    input  logic [AW-1:0] base_b_i,
    input  logic [1:0]    host_empty_i,
    input  logic          word_vld_i,
    input  logic [31:0]   word_i,
    output logic          take_o,
    input  logic          wr_ready_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [31:0]   wr_data_o,
    output logic          wr_last_o,
    output logic [1:0]    buf_full_o
);

    localparam int BW = $clog2(BURST);

    typedef struct packed {
        wr_st_e        st;
        logic          cur;
        logic [SW-1:0] size;
        logic [AW-1:0] base_a;
        logic [AW-1:0] base_b;
        logic [SW-1:0] off;
        logic [BW-1:0] beat;
        logic [1:0]    full;
    } wr_t;

    wr_t  r_q, r_d;
    logic fire;
    logic buf_done;

    always_comb begin
        r_d        = r_q;
        wr_valid_o = (r_q.st == WR_BURST) && word_vld_i;
        fire       = wr_valid_o && wr_ready_i;
        take_o     = fire;
        buf_done   = ({1'b0, r_q.off} + (SW+1)'(BURST)) >= {1'b0, r_q.size};
        r_d.full   = r_q.full & ~host_empty_i;
        unique case (r_q.st)
            WR_IDLE: begin
                if (start_i) begin
                    r_d.st     = WR_WAIT;
                    r_d.size   = {buf_words_i[SW-1:BW], BW'(0)};
                    r_d.base_a = base_a_i;
                    r_d.base_b = base_b_i;
                    r_d.cur    = 1'b0;
                    r_d.off    = '0;
                    r_d.beat   = '0;
                end
            end
            WR_WAIT: begin
                if (!r_q.full[r_q.cur]) r_d.st = WR_BURST;
            end
            WR_BURST: begin
                if (fire) begin
                    if (r_q.beat == BW'(BURST - 1)) begin
                        r_d.beat = '0;
                        if (buf_done) begin
                            r_d.full[r_q.cur] = 1'b1;
                            r_d.cur           = ~r_q.cur;
                            r_d.off           = '0;
                            r_d.st            = WR_WAIT;
                        end else begin
                            r_d.off = r_q.off + SW'(BURST);
                        end
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_addr_o  = (r_q.cur ? r_q.base_b : r_q.base_a) + (AW'(r_q.off) << 2);
    assign wr_data_o  = word_i;
    assign wr_last_o  = (r_q.beat == BW'(BURST - 1));
    assign buf_full_o = r_q.full;

endmodule

// File: rtl/mtg_pingpong_gen.sv
module mtg_pingpong_gen
    import mtg_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SW    = 16,
    parameter int BURST = 16,
    parameter int N     = STATE_WORDS,
    parameter int M     = SHIFT_DIST,
    parameter int LW    = $clog2(BURST) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   seed_i,
    input  logic [SW-1:0] buf_words_i,
    input  logic [AW-1:0] base_a_i,
    input  logic [AW-1:0] base_b_i,
    input  logic [1:0]    host_empty_i,
    output logic [1:0]    buf_full_o,
    output logic          wr_valid_o,
    input  logic          wr_ready_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [LW-1:0] wr_len_o,
    output logic [31:0]   wr_data_o,
    output logic          wr_last_o
);

    logic        take;
    logic        word_vld;
    logic [31:0] word;

    mtg_core #(.N(N), .M(M)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .seed_i     (seed_i),
        .take_i     (take),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    mtg_writer #(.AW(AW), .SW(SW), .BURST(BURST)) i_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .buf_words_i  (buf_words_i),
        .base_a_i     (base_a_i),
        .base_b_i     (base_b_i),
        .host_empty_i (host_empty_i),
        .word_vld_i   (word_vld),
        .word_i       (word),
        .take_o       (take),
        .wr_ready_i   (wr_ready_i),
        .wr_valid_o   (wr_valid_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .wr_last_o    (wr_last_o),
        .buf_full_o   (buf_full_o)
    );

    assign wr_len_o = LW'(BURST);

endmodule

// File: rtl/mtg_pingpong_gen_chk.sv
module mtg_pingpong_gen_chk #(
    parameter int AW    = 32,
    parameter int BURST = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid_o,
    input logic          wr_ready_i,
    input logic [AW-1:0] wr_addr_o,
    input logic [31:0]   wr_data_o,
    input logic          wr_last_o,
    input logic [1:0]    buf_full_o,
    input logic [1:0]    host_empty_i
);

    localparam int BW = $clog2(BURST);

    logic [BW-1:0] beat_q;
    logic          tgt_q;
    logic [1:0]    prev_full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q      <= '0;
            tgt_q       <= 1'b0;
            prev_full_q <= '0;
        end else begin
            if (wr_valid_o && wr_ready_i) beat_q <= beat_q + 1'b1;
            if (|(buf_full_o & ~prev_full_q)) tgt_q <= ~tgt_q;
            prev_full_q <= buf_full_o;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o)
                                      && $stable(wr_addr_o) && $stable(wr_last_o));

    p_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_last_o == (beat_q == BW'(BURST - 1))));

    p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_ready_i && !wr_last_o |=> $stable(wr_addr_o));

    p_rise_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o[0]) |-> $past(wr_valid_o && wr_ready_i && wr_last_o));

    p_rise_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o[1]) |-> $past(wr_valid_o && wr_ready_i && wr_last_o));

    p_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !buf_full_o[tgt_q]);

    p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_empty_i[0] && buf_full_o[0] |=> !buf_full_o[0]);

    p_clear_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_empty_i[1] && buf_full_o[1] |=> !buf_full_o[1]);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r10: assert (!wr_valid_o && buf_full_o == 2'b00);
        end
    end

endmodule

bind mtg_pingpong_gen mtg_pingpong_gen_chk #(.AW(AW), .BURST(BURST)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid_o   (wr_valid_o),
    .wr_ready_i   (wr_ready_i),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .wr_last_o    (wr_last_o),
    .buf_full_o   (buf_full_o),
    .host_empty_i (host_empty_i)
);

// File: tb/test_mtg_pingpong_gen.sv
`timescale 1ns/1ps
module test_mtg_pingpong_gen;

    localparam int AW = 32;
    localparam int SW = 16;
    localparam int LW = 5;
    localparam int TOTAL = 1000;
    localparam int BUFW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [31:0]   seed_i = '0;
    logic [SW-1:0] buf_words_i = '0;
    logic [AW-1:0] base_a_i = '0;
    logic [AW-1:0] base_b_i = '0;
    logic [1:0]    host_empty_i = '0;
    logic [1:0]    buf_full_o;
    logic          wr_valid_o;
    logic          wr_ready_i = 1'b0;
    logic [AW-1:0] wr_addr_o;
    logic [LW-1:0] wr_len_o;
    logic [31:0]   wr_data_o;
    logic          wr_last_o;

    always #10 clk = ~clk;

    mtg_pingpong_gen i_mtg_pingpong_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .buf_words_i(buf_words_i), .base_a_i(base_a_i), .base_b_i(base_b_i),
        .host_empty_i(host_empty_i), .buf_full_o(buf_full_o),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
        .wr_len_o(wr_len_o), .wr_data_o(wr_data_o), .wr_last_o(wr_last_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference generator: bulk regeneration of the whole state
    int unsigned ref_st [624];
    int          ref_pos;

    function automatic void ref_init(input int unsigned s);
        ref_st[0] = s;
        for (int i = 1; i < 624; i++)
            ref_st[i] = 32'd1812433253 * (ref_st[i-1] ^ (ref_st[i-1] >> 30)) + i;
        ref_pos = 624;
    endfunction

    function automatic int unsigned ref_next();
        int unsigned y;
        if (ref_pos >= 624) begin
            for (int i = 0; i < 624; i++) begin
                y = (ref_st[i] & 32'h8000_0000) | (ref_st[(i + 1) % 624] & 32'h7FFF_FFFF);
                ref_st[i] = ref_st[(i + 397) % 624] ^ (y >> 1) ^ ((y & 1) != 0 ? 32'h9908_B0DF : 0);
            end
            ref_pos = 0;
        end
        y = ref_st[ref_pos];
        ref_pos++;
        y ^= y >> 11;
        y ^= (y << 7) & 32'h9D2C_5680;
        y ^= (y << 15) & 32'hEFC6_0000;
        y ^= y >> 18;
        return y;
    endfunction

    initial begin
        int unsigned exp_word;
        logic [AW-1:0] exp_base [2];
        bit   [1:0] exp_full;
        int   cd [2];
        int   cur, beat, off, nwords, done_bufs, cyc, start_cyc, first_cyc;
        int   stall, stall_done;
        logic [31:0] held;
        bit   r, restart_done;

        void'($urandom(32'd2024));
        exp_full = '0; cd[0] = 0; cd[1] = 0;
        cur = 0; beat = 0; off = 0; nwords = 0; done_bufs = 0; cyc = 0;
        first_cyc = -1; stall = 0; stall_done = 0; held = '0; restart_done = 0;

        repeat (3) @(negedge clk);
        chk(!wr_valid_o && buf_full_o == 2'b00, "R10 reset state", {wr_valid_o, buf_full_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid_o && buf_full_o == 2'b00, "R10 after reset", {wr_valid_o, buf_full_o}, 0);

        // empty pulse on empty flags: no effect
        host_empty_i = 2'b11;
        @(negedge clk);
        host_empty_i = 2'b00;
        @(negedge clk);
        chk(buf_full_o == 2'b00, "R8 clear of empty flag", buf_full_o, 0);

        seed_i      = 32'd5489;
        buf_words_i = SW'(BUFW + 5);
        base_a_i    = 32'h0000_1000;
        base_b_i    = 32'h0004_0000;
        exp_base[0] = base_a_i;
        exp_base[1] = base_b_i;
        ref_init(32'd5489);
        start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;

        while (nwords < TOTAL && cyc < 60000) begin
            cyc++;
            chk(buf_full_o == exp_full, "R6 flag state", buf_full_o, exp_full);
            if (wr_valid_o) chk(!exp_full[cur], "R7 beat while buffer full", cur, 0);
            if (wr_valid_o && first_cyc < 0) begin
                first_cyc = cyc;
                chk((cyc - start_cyc) >= 624 && (cyc - start_cyc) <= 640,
                    "R1 seeding latency", cyc - start_cyc, 626);
            end

            // host side of the flags
            host_empty_i = 2'b00;
            for (int b = 0; b < 2; b++) begin
                if (exp_full[b]) begin
                    if (cd[b] == 0) begin
                        host_empty_i[b] = 1'b1;
                        exp_full[b] = 1'b0;
                    end else cd[b]--;
                end else if (b != cur && ($urandom % 20) == 0) begin
                    host_empty_i[b] = 1'b1;
                end
            end

            // mid-run restart attempt with changed configuration
            start_i = 1'b0;
            if (nwords >= 100 && !restart_done) begin
                restart_done = 1;
                start_i = 1'b1;
                seed_i = 32'd1;
                buf_words_i = SW'(32);
                base_a_i = 32'h00F0_0000;
                base_b_i = 32'h00E0_0000;
            end

            // ready with a directed long stall
            if (stall > 0) begin
                chk(wr_valid_o && wr_data_o == held, "R3 hold under stall", wr_data_o, held);
                r = 1'b0;
                stall--;
            end else if (!stall_done && nwords >= 200 && wr_valid_o) begin
                stall = 40; stall_done = 1; held = wr_data_o; r = 1'b0;
            end else begin
                r = ($urandom % 100) < 70;
            end
            wr_ready_i = r;

            if (wr_valid_o && r) begin
                exp_word = ref_next();
                chk(wr_data_o == exp_word, "R2 data", wr_data_o, exp_word);
                if (nwords == 0) chk(wr_data_o == 32'd3499211612, "R2 first word", wr_data_o, 32'd3499211612);
                if (restart_done) chk(1'b1, "R9 restart ignored", 0, 0);
                chk(wr_addr_o == exp_base[cur] + 32'(off) * 4, "R5 R4 burst address",
                    wr_addr_o, exp_base[cur] + 32'(off) * 4);
                chk(wr_last_o == (beat == 15), "R4 last flag", wr_last_o, beat == 15);
                chk(wr_len_o == 5'd16, "R4 burst length", wr_len_o, 16);
                nwords++;
                if (beat == 15) begin
                    beat = 0;
                    if (off + 16 >= BUFW) begin
                        exp_full[cur] = 1'b1;
                        done_bufs++;
                        cd[cur] = (done_bufs == 4) ? 200 : int'($urandom % 30);
                        cur = 1 - cur;
                        off = 0;
                    end else off += 16;
                end else beat++;
            end
            @(negedge clk);
        end
        if (nwords < TOTAL) chk(1'b0, "watchdog expired", nwords, TOTAL);
        chk(done_bufs >= 15, "R5 alternating buffers completed", done_bufs, 15);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule